// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block is a watchdog with two countdown stages that run one after the other. The first stage counts a programmed number of ticks and can raise a level interrupt when it runs out. The second stage then counts its own programmed number of ticks. When it runs out in watchdog mode, the block emits a one-cycle reset pulse and sets a sticky timeout flag. The count then begins again at stage one. Software keeps the system alive by kicking the watchdog before stage two runs out.

The two preload registers and the reload/status register are protected. A single write to any of them is accepted only after two key bytes, 0x80 and then 0x86, have been written to the reload register. Accepting that one write locks them again. The tick comes from a prescaler that divides the input clock by one of two powers of two. A lock/enable register starts and stops the counters. Its lock bit, once set, holds the enable on until the next reset.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, both preloads read 0xFFFFF. Status (0x08), reload (0x0C), config (0x10) and lock (0x14) all read 0. `irq` and `rstPulse` are low.
- R2: Write 0x80 and then 0x86 to the reload register (0x0C), bits 7:0. After that, exactly one write to a protected register (0x00, 0x04, 0x0C) is accepted, and the block relocks.
- R3: A write to a protected register is ignored when no key sequence precedes it. A reload write that does not continue the key sequence sends the sequence back to its start. For example, 0x80, 0x55, 0x86 does not unlock.
- R4: Each preload (0x00 stage one, 0x04 stage two) holds 20 bits and reads back as written. A stored zero counts as one tick.
- R5: With config bit 2 at 0, a tick occurs every 2^PRE_LOG2 clocks. With config bit 2 at 1, a tick occurs every 2^FAST_LOG2 clocks. Counting starts from the enable or kick write.
- R6: Stage one expires after its preload number of ticks. On expiry it sets status bit 0 and drives `irq` high, unless config bits 1:0 are 11. Writing 1 to status bit 0 clears it; this write needs no key.
- R7: Stage two then counts its own preload. In watchdog mode its expiry sets reload bit 9 (the sticky flag) and gives a one-cycle `rstPulse`. Stage one then restarts.
- R8: With config bit 5 at 1, `rstPulse` stays low, but stage-two expiry still sets the sticky flag.
- R9: An accepted write of reload bit 8 restarts stage one from its preload and restarts the prescaler.
- R10: An accepted write of reload bit 9 as 1 clears the sticky flag.
- R11: In the lock register, bit 1 is the enable and bit 2 is the mode. Bit 0 is a lock that, once set, stays set until reset. While the lock is set, the enable cannot be cleared and the mode cannot be changed.
- R12: While disabled, both stages are held at their preloads, and `irq` and `rstPulse` do not assert. A fresh enable counts the full stage-one time.
- R13: With lock bit 2 at 1 (timer mode), stage-two expiry neither pulses `rstPulse` nor sets the sticky flag. Stage one restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Stage-one expiry interrupt, level |
| rstPulse | output | 1 | One-cycle reset request on stage-two expiry |

## Verification
A wrong key-state register appears at once as a preload readback that did or did not change after a single write. A stale stage or count register first appears only when the next tick lands. It shows as an `irq` or `rstPulse` edge that comes earlier or later than the count of preload ticks times the tick period. Timing is therefore measured in clocks from the enable or kick write. A reference model compares `irq`, `rstPulse` and the addressed readback on every clock, so a divergence is reported in the cycle it appears.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_PRE1 = 5'h00;
  localparam logic [ADDR_W-1:0] A_PRE2 = 5'h04;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h08;
  localparam logic [ADDR_W-1:0] A_RLD  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_CFG  = 5'h10;
  localparam logic [ADDR_W-1:0] A_LOCK = 5'h14;
  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_OPEN} keyState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic kick;
    logic fastRate;
  } dpCtl_t;
endpackage

// File: rtl/wdt_datapath.sv
`timescale 1ns/1ps
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int PRE_LOG2  = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [CNT_W-1:0] pre1Eff,
  input  logic [CNT_W-1:0] pre2Eff,
  output logic             expire1,
  output logic             expire2
);
  localparam logic [PRE_LOG2-1:0] SLOW_MASK = '1;
  localparam logic [PRE_LOG2-1:0] FAST_MASK = PRE_LOG2'((64'(1) << FAST_LOG2) - 64'(1));
  localparam logic [CNT_W-1:0]    ONE       = CNT_W'(1);

  logic [PRE_LOG2-1:0] preCnt;
  logic [PRE_LOG2-1:0] tickMask;
  logic                tick;
  logic                inStage2;
  logic [CNT_W-1:0]    count;
  logic                lastTick;

  assign tickMask = ctl.fastRate ? FAST_MASK : SLOW_MASK;
  assign tick     = ctl.run && ((preCnt & tickMask) == tickMask);
  assign lastTick = tick && !ctl.kick && (count == ONE);
  assign expire1  = lastTick && !inStage2;
  assign expire2  = lastTick && inStage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!ctl.run || ctl.kick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inStage2 <= 1'b0;
      count    <= '1;
    end else if (!ctl.run || ctl.kick) begin
      inStage2 <= 1'b0;
      count    <= pre1Eff;
    end else if (tick) begin
      if (count == ONE) begin
        inStage2 <= !inStage2;
        count    <= inStage2 ? pre1Eff : pre2Eff;
      end else begin
        count <= count - ONE;
      end
    end
  end

  // R4
  count_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    count != '0);
  // R6
  stage_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inStage2) |-> $past(expire1));
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> (!inStage2 && count == $past(pre1Eff)));
endmodule

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic              expire1,
  input  logic              expire2,
  output logic [31:0]       rdData,
  output logic              irq,
  output logic              rstPulse,
  output dpCtl_t            ctl,
  output logic [CNT_W-1:0]  pre1Eff,
  output logic [CNT_W-1:0]  pre2Eff
);
  localparam int N_STAGE = 2;

  keyState_t        keyState, keyNext;
  logic [CNT_W-1:0] preReg [N_STAGE];
  logic [CNT_W-1:0] preEff [N_STAGE];
  logic             irqPend, sticky;
  logic             cfgRstOff, cfgFast;
  logic [1:0]       cfgInt;
  logic             lockBit, enBit, modeBit;
  logic             rldWr, protWr, accept, resetEvent;
  logic             unusedBits;

  assign unusedBits = ^wrData;
  assign rldWr      = wrEn && (addr == A_RLD);
  assign protWr     = wrEn && (addr == A_PRE1 || addr == A_PRE2 || addr == A_RLD);
  assign accept     = protWr && (keyState == KEY_OPEN);
  assign resetEvent = expire2 && !modeBit;

  always_comb begin
    keyNext = keyState;
    if (accept) begin
      keyNext = KEY_IDLE;
    end else if (rldWr) begin
      unique case (keyState)
        KEY_IDLE: keyNext = (wrData[7:0] == KEY_FIRST) ? KEY_HALF : KEY_IDLE;
        KEY_HALF: begin
          if (wrData[7:0] == KEY_SECOND)     keyNext = KEY_OPEN;
          else if (wrData[7:0] == KEY_FIRST) keyNext = KEY_HALF;
          else                               keyNext = KEY_IDLE;
        end
        default:  keyNext = KEY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= KEY_IDLE;
    else       keyState <= keyNext;
  end

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(4 * s);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         preReg[s] <= '1;
      else if (accept && addr == MY_ADDR) preReg[s] <= wrData[CNT_W-1:0];
    end
    assign preEff[s] = (preReg[s] == '0) ? CNT_W'(1) : preReg[s];
  end
  assign pre1Eff = preEff[0];
  assign pre2Eff = preEff[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPend  <= 1'b0;
      sticky   <= 1'b0;
      rstPulse <= 1'b0;
    end else begin
      rstPulse <= resetEvent && !cfgRstOff;
      if (expire1 && cfgInt != 2'b11)                irqPend <= 1'b1;
      else if (wrEn && addr == A_STAT && wrData[0])  irqPend <= 1'b0;
      if (resetEvent)                                sticky  <= 1'b1;
      else if (accept && addr == A_RLD && wrData[9]) sticky  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRstOff <= 1'b0;
      cfgFast   <= 1'b0;
      cfgInt    <= 2'b00;
    end else if (wrEn && addr == A_CFG) begin
      cfgRstOff <= wrData[5];
      cfgFast   <= wrData[2];
      cfgInt    <= wrData[1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBit <= 1'b0;
      enBit   <= 1'b0;
      modeBit <= 1'b0;
    end else if (wrEn && addr == A_LOCK) begin
      lockBit <= lockBit | wrData[0];
      enBit   <= wrData[1] | (lockBit & enBit);
      if (!lockBit) modeBit <= wrData[2];
    end
  end

  assign ctl.run      = enBit;
  assign ctl.kick     = accept && (addr == A_RLD) && wrData[8];
  assign ctl.fastRate = cfgFast;
  assign irq          = irqPend;

  always_comb begin
    unique case (addr)
      A_PRE1:  rdData = 32'(preReg[0]);
      A_PRE2:  rdData = 32'(preReg[1]);
      A_STAT:  rdData = {31'b0, irqPend};
      A_RLD:   rdData = {22'b0, sticky, 9'b0};
      A_CFG:   rdData = {26'b0, cfgRstOff, 2'b00, cfgFast, cfgInt};
      A_LOCK:  rdData = {29'b0, modeBit, enBit, lockBit};
      default: rdData = '0;
    endcase
  end

  // R2
  key_relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (keyState != KEY_OPEN));
  // R7
  rst_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |=> !rstPulse);
  // R7
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |-> sticky);
  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockBit |=> (lockBit && ($past(enBit) -> enBit)));
  // R12
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> !rstPulse);
endmodule

// File: rtl/twostage_wdt.sv
`timescale 1ns/1ps
module twostage_wdt
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int PRE_LOG2  = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [4:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irq,
  output logic        rstPulse
);
  dpCtl_t           ctl;
  logic [CNT_W-1:0] pre1Eff, pre2Eff;
  logic             expire1, expire2;

  wdt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .expire1(expire1), .expire2(expire2), .rdData(rdData), .irq(irq),
    .rstPulse(rstPulse), .ctl(ctl), .pre1Eff(pre1Eff), .pre2Eff(pre2Eff)
  );

  wdt_datapath #(.CNT_W(CNT_W), .PRE_LOG2(PRE_LOG2), .FAST_LOG2(FAST_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pre1Eff(pre1Eff), .pre2Eff(pre2Eff),
    .expire1(expire1), .expire2(expire2)
  );
endmodule

// File: tb/twostage_wdt_tb.sv
`timescale 1ns/1ps
module twostage_wdt_tb;
  localparam int PRE  = 4;
  localparam int FAST = 1;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [4:0] addr = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rdData;
  logic irq, rstPulse;
  int tests = 0, fails = 0;
  bit done = 0;

  twostage_wdt #(.CNT_W(20), .PRE_LOG2(PRE), .FAST_LOG2(FAST)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq), .rstPulse(rstPulse));

  always #10 clk = ~clk;

  // behavioural reference model
  int mPre0, mPre1, mKey, mPsc, mStage, mCnt, mInt;
  bit mIrq, mSticky, mRst, mRstOff, mFast, mLock, mEn, mMode;
  int per;
  bit tk, kk, e1, e2, acc, prot, rld;

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [31:0] expRead(logic [4:0] a);
    case (a)
      5'h00: return mPre0;
      5'h04: return mPre1;
      5'h08: return {31'b0, mIrq};
      5'h0C: return mSticky ? 32'h200 : 32'h0;
      5'h10: return (mRstOff ? 32'h20 : 0) | (mFast ? 32'h4 : 0) | mInt;
      5'h14: return (mMode ? 32'h4 : 0) | (mEn ? 32'h2 : 0) | (mLock ? 32'h1 : 0);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPre0 = 20'hFFFFF; mPre1 = 20'hFFFFF; mKey = 0; mPsc = 0; mStage = 1;
      mCnt = 20'hFFFFF; mInt = 0; mIrq = 0; mSticky = 0; mRst = 0;
      mRstOff = 0; mFast = 0; mLock = 0; mEn = 0; mMode = 0;
    end else begin
      rld  = wrEn && addr == 5'h0C;
      prot = wrEn && (addr == 5'h00 || addr == 5'h04 || addr == 5'h0C);
      acc  = prot && mKey == 2;
      kk   = acc && rld && wrData[8];
      per  = mFast ? (1 << FAST) : (1 << PRE);
      tk   = mEn && ((mPsc % per) == per - 1);
      e1   = tk && !kk && mStage == 1 && mCnt == 1;
      e2   = tk && !kk && mStage == 2 && mCnt == 1;
      if (!mEn || kk) begin mStage = 1; mCnt = eff(mPre0); end
      else if (tk) begin
        if (mCnt > 1) mCnt = mCnt - 1;
        else if (mStage == 1) begin mStage = 2; mCnt = eff(mPre1); end
        else begin mStage = 1; mCnt = eff(mPre0); end
      end
      mPsc = (!mEn || kk) ? 0 : (mPsc + 1) % (1 << PRE);
      mRst = e2 && !mMode && !mRstOff;
      if (e2 && !mMode) mSticky = 1;
      else if (acc && rld && wrData[9]) mSticky = 0;
      if (e1 && mInt != 3) mIrq = 1;
      else if (wrEn && addr == 5'h08 && wrData[0]) mIrq = 0;
      if (acc) mKey = 0;
      else if (rld) begin
        if (wrData[7:0] == 8'h80) mKey = 1;
        else if (mKey == 1 && wrData[7:0] == 8'h86) mKey = 2;
        else mKey = 0;
      end
      if (acc && addr == 5'h00) mPre0 = wrData[19:0];
      if (acc && addr == 5'h04) mPre1 = wrData[19:0];
      if (wrEn && addr == 5'h10) begin
        mRstOff = wrData[5]; mFast = wrData[2]; mInt = wrData[1:0];
      end
      if (wrEn && addr == 5'h14) begin
        mEn = wrData[1] | (mLock & mEn);
        if (!mLock) mMode = wrData[2];
        mLock = mLock | wrData[0];
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      tests++;
      if (irq !== mIrq || rstPulse !== mRst || rdData !== expRead(addr)) begin
        fails++;
        $display("FAIL model R6/R7 irq=%b/%b rstPulse=%b/%b rdData=%h/%h (actual/expected)",
                 irq, mIrq, rstPulse, mRst, rdData, expRead(addr));
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #2; wrEn = 1; addr = a; wrData = d;
    @(posedge clk); #2; wrEn = 0; wrData = 0;
  endtask

  task automatic unlock();
    wr(5'h0C, 32'h80); wr(5'h0C, 32'h86);
  endtask

  task automatic rdChk(logic [4:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #2; addr = a;
    @(negedge clk); chk(tag, rdData, exp);
  endtask

  task automatic waitSig(bit useRst, int start, int limit, output int n);
    n = start;
    do begin
      @(posedge clk); #2; n++;
    end while (!(useRst ? rstPulse : irq) && n < limit);
  endtask

  task automatic quiet(bit useRst, int cycles, string tag);
    bit seen = 0;
    repeat (cycles) begin
      @(posedge clk); #2;
      if (useRst ? rstPulse : irq) seen = 1;
    end
    chk(tag, {31'b0, seen}, 32'h0);
  endtask

  task automatic restartTimer(logic [31:0] cfg, logic [31:0] lockVal);
    wr(5'h14, 0); wr(5'h08, 1); wr(5'h10, cfg); wr(5'h14, lockVal);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    // R1 reset state
    rdChk(5'h00, 32'hFFFFF, "R1"); rdChk(5'h04, 32'hFFFFF, "R1");
    rdChk(5'h08, 0, "R1"); rdChk(5'h0C, 0, "R1");
    rdChk(5'h10, 0, "R1"); rdChk(5'h14, 0, "R1");
    chk("R1", {30'b0, irq, rstPulse}, 0);
    // R3 write without key ignored
    wr(5'h00, 5); rdChk(5'h00, 32'hFFFFF, "R3");
    // R2 one write per unlock
    unlock(); wr(5'h00, 5); rdChk(5'h00, 5, "R2");
    wr(5'h00, 7); rdChk(5'h00, 5, "R2");
    // R3 broken key sequence
    wr(5'h0C, 32'h80); wr(5'h0C, 32'h55); wr(5'h0C, 32'h86); wr(5'h04, 3);
    rdChk(5'h04, 32'hFFFFF, "R3");
    unlock(); wr(5'h04, 3); rdChk(5'h04, 3, "R2");
    // R12 disabled stays quiet
    quiet(0, 200, "R12"); rdChk(5'h08, 0, "R12");
    // R5 R6 R7 slow tick, full cycle
    wr(5'h10, 0); wr(5'h14, 2);
    waitSig(0, 0, 400, n); chk("R6 irq time", n, 80);
    waitSig(1, n, 400, n); chk("R7 rst time", n, 128);
    @(posedge clk); #2; chk("R7 pulse width", {31'b0, rstPulse}, 0);
    rdChk(5'h0C, 32'h200, "R7"); rdChk(5'h08, 1, "R6");
    wr(5'h08, 1); chk("R6 clear", {31'b0, irq}, 0);
    // R10 sticky clear
    unlock(); wr(5'h0C, 32'h200); rdChk(5'h0C, 0, "R10");
    // R9 keepalive
    restartTimer(0, 2);
    repeat (40) @(posedge clk);
    unlock(); wr(5'h0C, 32'h100);
    waitSig(0, 0, 400, n); chk("R9 irq after kick", n, 80);
    // R8 reset output disabled
    restartTimer(32'h20, 2);
    waitSig(0, 0, 400, n); chk("R8 irq time", n, 80);
    quiet(1, 60, "R8"); rdChk(5'h0C, 32'h200, "R8");
    // R5 fast tick
    restartTimer(32'h24, 2);
    waitSig(0, 0, 400, n); chk("R5 fast irq", n, 10);
    // R6 interrupt disabled
    restartTimer(32'h27, 2);
    quiet(0, 30, "R6"); rdChk(5'h08, 0, "R6");
    // R4 zero preloads
    wr(5'h14, 0); unlock(); wr(5'h00, 0); unlock(); wr(5'h04, 0);
    rdChk(5'h00, 0, "R4");
    restartTimer(32'h04, 2);
    waitSig(0, 0, 400, n); chk("R4 irq time", n, 2);
    waitSig(1, n, 400, n); chk("R4 rst time", n, 4);
    // R13 timer mode
    wr(5'h14, 0); unlock(); wr(5'h00, 5); unlock(); wr(5'h04, 3);
    unlock(); wr(5'h0C, 32'h200);
    restartTimer(32'h04, 6);
    waitSig(0, 0, 400, n); chk("R13 irq time", n, 10);
    quiet(1, 40, "R13"); rdChk(5'h0C, 0, "R13"); rdChk(5'h14, 6, "R13");
    // R11 lock
    wr(5'h14, 3); rdChk(5'h14, 3, "R11");
    wr(5'h14, 0); rdChk(5'h14, 3, "R11");
    wr(5'h14, 7); rdChk(5'h14, 3, "R11");
    // R1 reset again clears lock
    @(posedge clk); #2; rstN = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    rdChk(5'h14, 0, "R1"); rdChk(5'h00, 32'hFFFFF, "R1");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule